// File: doc/BRIEF.md
# Receive Queue Wait-Flow Controller

This block sits at the receive input of a link. Incoming transactions land in a main queue, which forwards them in arrival order to a set of secondary queues. Each transaction carries the index of its secondary queue in its low data bits. When any secondary queue reports that it is full, the block raises a wait request toward the remote transmitter.

The main queue is sized to absorb every transaction already in flight while that request travels back across the link. The stop point can shift by one cycle in either direction because of synchronisation on the way. For this reason the request is held until the main queue has drained to empty, not merely below some level. After every stall the full in-flight allowance is then available again. Pushes that arrive while the request is up are still accepted. A push into a full queue is dropped and latches an overflow flag.

An elaboration check rejects a queue depth smaller than the in-flight limit plus one. Crossing the wait request into the transmitter's clock domain belongs to the surrounding logic.

Top module: `rxq_wait_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `fill_level` is 0, `wait_req` is 0, `overflow` is 0 and `sec_push` is all zeros.
- R2: A push into a non-full queue with no forward in the same cycle raises `fill_level` by one at the next clock edge. `fill_level` never exceeds DEPTH.
- R3: Transactions leave the main queue in exactly the order in which they were accepted.
- R4: The head's destination is its data bits [SELW-1:0]. When the queue is non-empty and `sec_full` of that destination is 0, `sec_push` is one-hot at that index, with `sec_data` equal to the head, in the same cycle. Otherwise `sec_push` is all zeros, even when other secondary queues have room (head-of-line blocking).
- R5: `wait_req` is 1 in the cycle after any bit of `sec_full` is sampled high.
- R6: Once `wait_req` is 1, it stays 1 while `fill_level` is non-zero, even after every `sec_full` bit has cleared.
- R7: `wait_req` returns to 0 one cycle after a cycle in which it was 1, `fill_level` was 0 and no `sec_full` bit was set.
- R8: Pushes are accepted while `wait_req` is 1.
- R9: A push while `fill_level` equals DEPTH is dropped and never forwarded. `overflow` becomes 1 at the next edge and stays 1 until reset.
- R10: A push and a forward in the same cycle leave `fill_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Push strobe for an incoming transaction |
| in_data | input | DW | Incoming transaction; bits [SELW-1:0] select the secondary queue |
| sec_full | input | NSEC | Full flag of each secondary queue |
| sec_push | output | NSEC | One-hot forward strobe toward a secondary queue |
| sec_data | output | DW | Transaction being forwarded (queue head) |
| wait_req | output | 1 | Wait request toward the remote transmitter |
| overflow | output | 1 | Sticky flag: a push was dropped on a full queue |
| fill_level | output | LW | Current main-queue occupancy |

## Verification
The stimulus table first stalls all secondary queues while three transactions with distinct destinations arrive, then releases them. This separates a release on empty from a release on the full flag clearing, and it shows arrival order across destinations. A second pattern stalls only the head's destination while the next entry's destination is free, which exposes any bypass of head-of-line order. The same pattern overlaps a push with a forward to catch level arithmetic errors. Directed tests fill the queue to its depth under a stall and push once more. They check that the extra entry is dropped, that the overflow flag latches and survives the drain, and that an asynchronous reset clears everything mid-cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_HOLD = 1'b1
  } wait_state_e;

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overflow
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_n;
  logic [PW-1:0] rd_ptr_q, rd_ptr_n;
  logic [LW-1:0] level_q, level_n;
  logic          ovf_q, ovf_n;
  logic          push_ok;
  logic          pop_ok;

  assign empty   = (level_q == '0);
  assign full    = (level_q == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    level_n  = level_q;
    ovf_n    = ovf_q | (push && full);
    if (push_ok) begin
      wr_ptr_n = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_n = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push_ok && !pop_ok) begin
      level_n = level_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      level_n = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      level_q  <= level_n;
      ovf_q    <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= push_data;
    end
  end

  assign head_data = mem_q[rd_ptr_q];
  assign level     = level_q;
  assign overflow  = ovf_q;

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (level == $past(level) + 1'b1));

endmodule

// File: rtl/rxq_route.sv
module rxq_route #(
  parameter int NSEC = 4,
  localparam int SELW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_valid,
  input  logic [SELW-1:0] head_dest,
  input  logic [NSEC-1:0] sec_full,
  output logic            pop,
  output logic [NSEC-1:0] sec_push
);

  logic dest_free;

  assign dest_free = !sec_full[head_dest];
  assign pop       = head_valid && dest_free;

  for (genvar gi = 0; gi < NSEC; gi++) begin : g_lane
    assign sec_push[gi] = pop && (head_dest == SELW'(gi));
  end

  // R4
  sec_push_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sec_push));

  // R4
  push_into_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_push & sec_full) == '0);

endmodule

// File: rtl/rxq_wait_fsm.sv
module rxq_wait_fsm
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_full,
  input  logic queue_empty,
  output logic wait_req
);

  wait_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      WS_IDLE: if (any_full) state_n = WS_HOLD;
      WS_HOLD: if (queue_empty && !any_full) state_n = WS_IDLE;
      default: state_n = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  assign wait_req = (state_q == WS_HOLD);

  // R5
  wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_full |=> wait_req);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !queue_empty) |=> wait_req);

  // R7
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && queue_empty && !any_full) |=> !wait_req);

endmodule

// File: rtl/rxq_wait_ctrl.sv
module rxq_wait_ctrl #(
  parameter int DW       = 16,
  parameter int NSEC     = 4,
  parameter int DEPTH    = 8,
  parameter int INFLIGHT = 6,
  localparam int SELW    = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int LW      = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic [NSEC-1:0] sec_full,
  output logic [NSEC-1:0] sec_push,
  output logic [DW-1:0]   sec_data,
  output logic            wait_req,
  output logic            overflow,
  output logic [LW-1:0]   fill_level
);

  if (DEPTH < INFLIGHT + 1) begin : g_depth_bad
    $error("rxq_wait_ctrl: DEPTH must be at least INFLIGHT + 1");
  end

  logic          rst_int_n;
  logic          q_pop;
  logic          q_empty;
  logic          q_full;
  logic [DW-1:0] q_head;

  rxq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rxq_fifo #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (in_valid),
    .push_data (in_data),
    .pop       (q_pop),
    .head_data (q_head),
    .level     (fill_level),
    .empty     (q_empty),
    .full      (q_full),
    .overflow  (overflow)
  );

  rxq_route #(
    .NSEC (NSEC)
  ) u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .head_valid (!q_empty),
    .head_dest  (q_head[SELW-1:0]),
    .sec_full   (sec_full),
    .pop        (q_pop),
    .sec_push   (sec_push)
  );

  rxq_wait_fsm u_wait_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .any_full    (|sec_full),
    .queue_empty (q_empty),
    .wait_req    (wait_req)
  );

  assign sec_data = q_head;

  // R9
  no_overflow_while_room_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!overflow && !(in_valid && q_full)) |=> !overflow);

endmodule

// File: tb/rxq_wait_ctrl_tb.sv
module rxq_wait_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic        vld;
    logic [15:0] din;
    logic [3:0]  full;
    logic [3:0]  epush;
    logic [15:0] edata;
    logic [3:0]  elvl;
    logic        ewait;
  } vec_t;

  // Destination is din[1:0]; sec_push bit i forwards to queue i.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h0000, 4'b0000, 4'b0000, 16'h0000, 4'd0, 1'b0}, // R1
    '{1'b1, 16'h1231, 4'b1111, 4'b0000, 16'h0000, 4'd0, 1'b0}, // R5 stimulus
    '{1'b1, 16'h4562, 4'b1111, 4'b0000, 16'h0000, 4'd1, 1'b1}, // R5 R8
    '{1'b1, 16'h7893, 4'b1111, 4'b0000, 16'h0000, 4'd2, 1'b1}, // R2 R8
    '{1'b0, 16'h0000, 4'b0000, 4'b0010, 16'h1231, 4'd3, 1'b1}, // R3 R4
    '{1'b0, 16'h0000, 4'b0000, 4'b0100, 16'h4562, 4'd2, 1'b1}, // R3 R6
    '{1'b0, 16'h0000, 4'b0000, 4'b1000, 16'h7893, 4'd1, 1'b1}, // R3 R6
    '{1'b0, 16'h0000, 4'b0000, 4'b0000, 16'h0000, 4'd0, 1'b1}, // R7 hold
    '{1'b0, 16'h0000, 4'b0000, 4'b0000, 16'h0000, 4'd0, 1'b0}, // R7 release
    '{1'b1, 16'h00A0, 4'b0001, 4'b0000, 16'h0000, 4'd0, 1'b0}, // R5 stimulus
    '{1'b1, 16'h00B1, 4'b0001, 4'b0000, 16'h0000, 4'd1, 1'b1}, // R4 blocking
    '{1'b0, 16'h0000, 4'b0000, 4'b0001, 16'h00A0, 4'd2, 1'b1}, // R4 R6
    '{1'b1, 16'h00C2, 4'b0000, 4'b0010, 16'h00B1, 4'd1, 1'b1}, // R10 R3
    '{1'b0, 16'h0000, 4'b0000, 4'b0100, 16'h00C2, 4'd1, 1'b1}, // R10 R3
    '{1'b0, 16'h0000, 4'b0000, 4'b0000, 16'h0000, 4'd0, 1'b1}, // R7 hold
    '{1'b0, 16'h0000, 4'b0000, 4'b0000, 16'h0000, 4'd0, 1'b0}  // R7 release
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [3:0]  sec_full;
  logic [3:0]  sec_push;
  logic [15:0] sec_data;
  logic        wait_req;
  logic        overflow;
  logic [3:0]  fill_level;

  int n_checks;
  int n_fails;
  bit done;

  rxq_wait_ctrl #(
    .DW       (16),
    .NSEC     (4),
    .DEPTH    (8),
    .INFLIGHT (6)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .sec_full   (sec_full),
    .sec_push   (sec_push),
    .sec_data   (sec_data),
    .wait_req   (wait_req),
    .overflow   (overflow),
    .fill_level (fill_level)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] d, input logic [3:0] f);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    sec_full = f;
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    sec_full = '0;
    rst_n    = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 level in reset", 32'(fill_level), 0);
    check("R1 wait in reset", 32'(wait_req), 0);
    check("R1 overflow in reset", 32'(overflow), 0);
    check("R1 sec_push in reset", 32'(sec_push), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].vld, VECS[i].din, VECS[i].full);
      check($sformatf("R4 sec_push vec %0d", i), 32'(sec_push), 32'(VECS[i].epush));
      if (VECS[i].epush != '0)
        check($sformatf("R3 sec_data vec %0d", i), 32'(sec_data), 32'(VECS[i].edata));
      check($sformatf("R2 fill_level vec %0d", i), 32'(fill_level), 32'(VECS[i].elvl));
      check($sformatf("R6 wait_req vec %0d", i), 32'(wait_req), 32'(VECS[i].ewait));
      check($sformatf("R9 overflow vec %0d", i), 32'(overflow), 0);
    end

    // R9 fill to depth under a stall, then one extra push
    for (int i = 0; i < 9; i++) begin
      drive(1'b1, (i < 8) ? 16'(16'h0100 + i * 4) : 16'h0FF0, 4'b1111);
      check($sformatf("R8 level while stalled %0d", i), 32'(fill_level), 32'(i));
      check("R4 no forward while full", 32'(sec_push), 0);
    end
    drive(1'b0, 16'h0000, 4'b1111);
    check("R9 level held at depth", 32'(fill_level), 8);
    check("R9 overflow set", 32'(overflow), 1);
    check("R5 wait during stall", 32'(wait_req), 1);
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, 16'h0000, 4'b0000);
      check($sformatf("R3 drain push %0d", i), 32'(sec_push), 32'b0001);
      check($sformatf("R3 drain data %0d", i), 32'(sec_data), 32'(16'h0100 + i * 4));
      check($sformatf("R6 wait during drain %0d", i), 32'(wait_req), 1);
    end
    drive(1'b0, 16'h0000, 4'b0000);
    check("R9 dropped entry not forwarded", 32'(sec_push), 0);
    check("R9 level empty after drain", 32'(fill_level), 0);
    check("R9 overflow sticky", 32'(overflow), 1);
    check("R7 wait still up on first empty cycle", 32'(wait_req), 1);
    drive(1'b0, 16'h0000, 4'b0000);
    check("R7 wait released", 32'(wait_req), 0);

    // R1 asynchronous reset in mid-cycle with state present
    drive(1'b1, 16'h0003, 4'b1000);
    drive(1'b0, 16'h0000, 4'b1000);
    check("R2 level before reset", 32'(fill_level), 1);
    #2 rst_n = 1'b0;
    #1;
    check("R1 level after async reset", 32'(fill_level), 0);
    check("R1 wait after async reset", 32'(wait_req), 0);
    check("R1 overflow after async reset", 32'(overflow), 0);
    check("R1 sec_push after async reset", 32'(sec_push), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    drive(1'b0, 16'h0000, 4'b0000);
    check("R1 level after release", 32'(fill_level), 0);
    check("R1 overflow after release", 32'(overflow), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule